// File: doc/BRIEF.md
# Serial Peripheral Master with Register Access

This block is a single-channel serial peripheral (SPI) master that software drives through a small set of memory-mapped registers: control, status, data, clock divisor and interrupt flag. Writing a word to the data register, with master operation enabled, starts one full-duplex transfer. The word is shifted out on `mosi` while `miso` is sampled, using the serial clock `sck` derived from the peripheral clock. When the word has been exchanged a completion flag is raised, the received word becomes readable, and an interrupt request can be raised.

All four clock polarity and phase combinations are supported, as are most-significant-bit-first and least-significant-bit-first ordering and word lengths from 8 to 16 bits. The serial clock period is set in peripheral clock cycles by an 8-bit divisor. The block forces that divisor to an even value of at least 8.

The register bus has no back-pressure. Each access with `bus_en` high completes in the cycle it is presented, and read data is valid in that same cycle. A data write that arrives while a word is still in flight is not queued. It is dropped and recorded as a collision.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control, status, divisor, data and interrupt registers all read 0, `irq` is low and `sck` is low.
- R2: Word length comes from control bit 2 (width enable) and bits 11:8 (width field). With bit 2 clear the length is 8 bits. With bit 2 set, field values 8 to 15 give that many bits, 0 gives 16 bits, and 1 to 7 give 8 bits. Data bits above the word length are not sent.
- R3: The divisor register (offset 0x0C, 8 bits) sets the `sck` period in peripheral clocks. A value below 8 acts as 8, and an odd value acts as the next even number. Each `sck` level lasts half the period. The completion flag becomes readable exactly N × period cycles after the cycle in which the data write was accepted, where N is the word length.
- R4: Control bit 4 (CPOL) sets the idle level of `sck`. With control bit 3 (CPHA) clear, `miso` is sampled and the receiver samples `mosi` on the first edge of each bit; with it set, both are sampled on the second edge. `mosi` changes only on the opposite edges.
- R5: Control bit 6 clear sends and receives the most significant bit first; bit 6 set sends and receives the least significant bit first.
- R6: A data register read (offset 0x08) returns the most recently received word, right-justified with zero upper bits. Only the low 8 bits are returned while width enable is clear.
- R7: Status bit 7 sets when a word completes. It clears only on a data register read or write that follows a status read (offset 0x04) which saw bit 7 set. A data access with no such preceding status read leaves it set.
- R8: A data write while a transfer is in flight is ignored and sets status bit 6. A status read clears that bit.
- R9: A word completing while status bit 7 is still set sets status bit 5, and the new word replaces the old one in the data register. A status read clears bit 5.
- R10: Interrupt register (offset 0x1C) bit 0 sets on every completion and clears when 1 is written to it. Writing 0 to it has no effect. `irq` is high exactly while control bit 7 and that flag are both set.
- R11: While control bit 5 (master) is clear, data writes start no transfer: `sck` stays at its idle level, and status and interrupt flags stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle. `sck` changes only on a divider tick and otherwise sits at the programmed polarity. `mosi` holds steady between ticks. A data write during a transfer raises the collision bit. The completion flag and `irq` rise only after a finished word or a control write. Bit order, mode-dependent sampling, word length decoding, the exact transfer duration, the read-then-access clearing sequence and the overrun case need a bench-side receiver and sequences across several register accesses, so only the bench's scenarios can show them.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int unsigned MAX_W  = 16;
  localparam int unsigned NB_W   = $clog2(MAX_W + 1);
  localparam int unsigned ADDR_W = 5;

  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CLKDIV = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_INTR   = 5'h1C;

  // control bit positions
  localparam int unsigned CB_WEN  = 2;
  localparam int unsigned CB_CPHA = 3;
  localparam int unsigned CB_CPOL = 4;
  localparam int unsigned CB_MSTR = 5;
  localparam int unsigned CB_LSB  = 6;
  localparam int unsigned CB_IEN  = 7;
  localparam int unsigned CB_WLO  = 8;
  localparam int unsigned WID_W   = 4;
  localparam logic [MAX_W-1:0] CTRL_KEEP = 16'h0FFC;

  // status bit positions
  localparam int unsigned SB_ROVR = 5;
  localparam int unsigned SB_WCOL = 6;
  localparam int unsigned SB_DONE = 7;

  typedef struct packed {
    logic            cpol;
    logic            cpha;
    logic            lsb_first;
    logic [NB_W-1:0] nbits;
  } xfer_cfg_t;

  // ones in the low n bit positions
  function automatic logic [MAX_W-1:0] low_mask(input logic [NB_W-1:0] n);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(MAX_W); i++) begin
      m[i] = (i < int'(n));
    end
    return m;
  endfunction

  // mirror the low n bits of a word, clearing the rest
  function automatic logic [MAX_W-1:0] flip_low(input logic [MAX_W-1:0] w,
                                                input logic [NB_W-1:0]  n);
    logic [MAX_W-1:0] r;
    logic [MAX_W-1:0] t;
    r = '0;
    for (int i = 0; i < int'(MAX_W); i++) begin
      t = w >> (int'(n) - 1 - i);
      r[i] = (i < int'(n)) ? t[0] : 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] half_in,
  input  logic             run,
  output logic             tick
);

  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;

  // the half period is frozen for the whole word
  assign tick = run && (cnt_q >= (half_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (start) begin
        half_q <= half_in;
      end
      if (!run || tick) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(2 * MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  xfer_cfg_t        start_cfg,
  input  logic [MAX_W-1:0] tx_word,
  input  logic             idle_pol,
  input  logic             tick,
  input  logic             miso,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  output logic             done,
  output logic [MAX_W-1:0] rx_word
);

  logic             busy_q;
  logic             sck_q;
  xfer_cfg_t        cfg_q;
  logic [MAX_W-1:0] tx_sh;
  logic [MAX_W-1:0] rx_sh;
  logic [MAX_W-1:0] rx_q;
  logic [CNT_W-1:0] edge_q;

  logic [CNT_W-1:0] edge_n;
  logic [CNT_W-1:0] edge_end;
  logic             samp_slot;
  logic             sample_e;
  logic             shift_e;
  logic             last_e;
  logic [MAX_W-1:0] rx_nx;
  logic [MAX_W-1:0] rx_right;
  logic [MAX_W-1:0] rx_done;

  assign edge_n    = edge_q + 1'b1;
  assign edge_end  = CNT_W'(cfg_q.nbits) << 1;
  // odd edges sample for phase 0, even edges for phase 1
  assign samp_slot = edge_n[0] ^ cfg_q.cpha;
  assign sample_e  = busy_q && tick && samp_slot;
  assign last_e    = busy_q && tick && (edge_n == edge_end);
  assign shift_e   = busy_q && tick && !samp_slot && (edge_n > CNT_W'(1)) && !last_e;

  // received bits enter at the top; the first one ends at MAX_W-n
  assign rx_nx    = sample_e ? {miso, rx_sh[MAX_W-1:1]} : rx_sh;
  assign rx_right = rx_nx >> (int'(MAX_W) - int'(cfg_q.nbits));
  assign rx_done  = cfg_q.lsb_first ? rx_right : flip_low(rx_right, cfg_q.nbits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cfg_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
      edge_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cfg_q  <= start_cfg;
      tx_sh  <= start_cfg.lsb_first ? (tx_word & low_mask(start_cfg.nbits))
                                    : flip_low(tx_word, start_cfg.nbits);
      rx_sh  <= '0;
      edge_q <= '0;
      sck_q  <= start_cfg.cpol;
    end else if (busy_q) begin
      if (tick) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_n;
        rx_sh  <= rx_nx;
        if (shift_e) begin
          tx_sh <= tx_sh >> 1;
        end
        if (last_e) begin
          busy_q <= 1'b0;
          rx_q   <= rx_done;
        end
      end
    end else begin
      sck_q <= idle_pol;
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = tx_sh[0];
  assign done    = last_e;
  assign rx_word = rx_q;

endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned MIN_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [MAX_W-1:0]  bus_wdata,
  output logic [MAX_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [MAX_W-1:0]  rx_word,
  output logic              start,
  output xfer_cfg_t         start_cfg,
  output logic [DIV_W-1:0]  half,
  output logic              idle_pol,
  output logic              ien,
  output logic              spif,
  output logic              wcol,
  output logic              irq
);

  localparam logic [DIV_W-1:0] MIN_CODE = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(MIN_DIV / 2);

  logic [MAX_W-1:0] ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             spif_q;
  logic             arm_q;
  logic             wcol_q;
  logic             rovr_q;
  logic             iflag_q;

  logic             hit_ctrl, hit_stat, hit_data, hit_div, hit_intr;
  logic             data_acc, data_wr, stat_rd, collide;
  logic [WID_W-1:0] wfield;
  logic [NB_W-1:0]  nbits;

  assign hit_ctrl = bus_en && (bus_addr == OFS_CTRL);
  assign hit_stat = bus_en && (bus_addr == OFS_STAT);
  assign hit_data = bus_en && (bus_addr == OFS_DATA);
  assign hit_div  = bus_en && (bus_addr == OFS_CLKDIV);
  assign hit_intr = bus_en && (bus_addr == OFS_INTR);

  assign data_acc = hit_data;
  assign data_wr  = hit_data && bus_we;
  assign stat_rd  = hit_stat && !bus_we;
  assign collide  = data_wr && busy;
  assign start    = data_wr && !busy && ctrl_q[CB_MSTR];

  // word length decode
  assign wfield = ctrl_q[CB_WLO +: WID_W];
  always_comb begin
    if (!ctrl_q[CB_WEN]) begin
      nbits = NB_W'(8);
    end else if (wfield == '0) begin
      nbits = NB_W'(MAX_W);
    end else if (wfield < WID_W'(8)) begin
      nbits = NB_W'(8);
    end else begin
      nbits = NB_W'(wfield);
    end
  end

  // effective divisor: at least MIN_DIV and even, kept as a half period
  always_comb begin
    if (div_q < MIN_CODE) begin
      half = MIN_HALF;
    end else begin
      half = (div_q >> 1) + DIV_W'(div_q[0]);
    end
  end

  assign start_cfg.cpol      = ctrl_q[CB_CPOL];
  assign start_cfg.cpha      = ctrl_q[CB_CPHA];
  assign start_cfg.lsb_first = ctrl_q[CB_LSB];
  assign start_cfg.nbits     = nbits;
  assign idle_pol            = ctrl_q[CB_CPOL];
  assign ien                 = ctrl_q[CB_IEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      spif_q  <= 1'b0;
      arm_q   <= 1'b0;
      wcol_q  <= 1'b0;
      rovr_q  <= 1'b0;
      iflag_q <= 1'b0;
    end else begin
      if (hit_ctrl && bus_we) begin
        ctrl_q <= bus_wdata & CTRL_KEEP;
      end
      if (hit_div && bus_we) begin
        div_q <= bus_wdata[DIV_W-1:0];
      end

      // completion flag: status read that saw it, then any data access
      if (done) begin
        spif_q <= 1'b1;
      end else if (data_acc && arm_q) begin
        spif_q <= 1'b0;
      end
      if (stat_rd && spif_q) begin
        arm_q <= 1'b1;
      end else if (data_acc) begin
        arm_q <= 1'b0;
      end

      if (collide) begin
        wcol_q <= 1'b1;
      end else if (stat_rd) begin
        wcol_q <= 1'b0;
      end
      if (done && spif_q) begin
        rovr_q <= 1'b1;
      end else if (stat_rd) begin
        rovr_q <= 1'b0;
      end

      if (done) begin
        iflag_q <= 1'b1;
      end else if (hit_intr && bus_we && bus_wdata[0]) begin
        iflag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      unique case (bus_addr)
        OFS_CTRL:   bus_rdata = ctrl_q;
        OFS_STAT: begin
          bus_rdata[SB_DONE] = spif_q;
          bus_rdata[SB_WCOL] = wcol_q;
          bus_rdata[SB_ROVR] = rovr_q;
        end
        OFS_DATA:   bus_rdata = ctrl_q[CB_WEN] ? rx_word : (rx_word & MAX_W'(16'h00FF));
        OFS_CLKDIV: bus_rdata = MAX_W'(div_q);
        OFS_INTR:   bus_rdata[0] = iflag_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign spif = spif_q;
  assign wcol = wcol_q;
  assign irq  = ien && iflag_q;

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned MIN_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [MAX_W-1:0]  bus_wdata,
  output logic [MAX_W-1:0]  bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);

  logic             start_w;
  xfer_cfg_t        cfg_w;
  logic [DIV_W-1:0] half_w;
  logic             cpol_w;
  logic             ien_w;
  logic             spif_w;
  logic             wcol_w;
  logic             busy_w;
  logic             tick_w;
  logic             done_w;
  logic [MAX_W-1:0] rx_w;

  spim_regs #(
    .DIV_W   (DIV_W),
    .MIN_DIV (MIN_DIV)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy_w),
    .done      (done_w),
    .rx_word   (rx_w),
    .start     (start_w),
    .start_cfg (cfg_w),
    .half      (half_w),
    .idle_pol  (cpol_w),
    .ien       (ien_w),
    .spif      (spif_w),
    .wcol      (wcol_w),
    .irq       (irq)
  );

  spim_divider #(
    .DIV_W (DIV_W)
  ) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start_w),
    .half_in (half_w),
    .run     (busy_w),
    .tick    (tick_w)
  );

  spim_shift shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .start_cfg (cfg_w),
    .tx_word   (bus_wdata),
    .idle_pol  (cpol_w),
    .tick      (tick_w),
    .miso      (miso),
    .busy      (busy_w),
    .sck       (sck),
    .mosi      (mosi),
    .done      (done_w),
    .rx_word   (rx_w)
  );

endmodule

// File: rtl/spim_chk.sv
module spim_chk
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              sck,
  input logic              mosi,
  input logic              irq,
  input logic              busy,
  input logic              tick,
  input logic              done,
  input logic              spif,
  input logic              wcol,
  input logic              cpol
);

  logic data_wr;
  logic ctrl_wr;
  assign data_wr = bus_en && bus_we && (bus_addr == OFS_DATA);
  assign ctrl_wr = bus_en && bus_we && (bus_addr == OFS_CTRL);

  // R3
  sck_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sck));

  // R4
  sck_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (sck == $past(cpol)));

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(mosi));

  // R7
  done_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif) |-> $past(done));

  // R8
  collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol);

  // R10
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done) || $past(ctrl_wr)));

endmodule

bind spim_ctrl spim_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .sck      (sck),
  .mosi     (mosi),
  .irq      (irq),
  .busy     (busy_w),
  .tick     (tick_w),
  .done     (done_w),
  .spif     (spif_w),
  .wcol     (wcol_w),
  .cpol     (cpol_w)
);

// File: tb/spim_ctrl_tb_top.sv
`timescale 1ns/1ps
module spim_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck, mosi, irq;
  logic        miso = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  spim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                         A_DIV = 5'h0C, A_INT = 5'h1C;

  // stimulus and expected results: control, divisor, tx, slave word, length, cycles
  localparam int NV = 9;
  localparam logic [15:0] V_CTRL [NV] = '{16'h0020, 16'h0028, 16'h0030, 16'h0078,
      16'h0C24, 16'h0064, 16'h0324, 16'h0F3C, 16'h0020};
  localparam logic [15:0] V_DIV  [NV] = '{16'h08, 16'h0A, 16'h03, 16'h09,
      16'h08, 16'h0C, 16'h08, 16'h10, 16'hFF};
  localparam logic [15:0] V_TX   [NV] = '{16'h00A5, 16'h005A, 16'h0081, 16'h0013,
      16'h0ABC, 16'hBEEF, 16'h01F5, 16'h7FFE, 16'h0000};
  localparam logic [15:0] V_SL   [NV] = '{16'h003C, 16'h00C3, 16'h007E, 16'h00E4,
      16'h05A6, 16'h1234, 16'h006D, 16'h4001, 16'h00FF};
  localparam int V_N   [NV] = '{8, 8, 8, 8, 12, 16, 8, 15, 8};
  localparam int V_CYC [NV] = '{64, 80, 64, 80, 96, 192, 64, 240, 2048};

  // bench-side receiver/transmitter
  int          s_n = 8;
  int          s_k = 0;
  logic        s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0, s_on = 1'b0;
  logic [15:0] s_word = '0, s_cap = '0;

  function automatic logic bit_at(input logic [15:0] w, input int pos);
    logic [15:0] t;
    t = w >> pos;
    return t[0];
  endfunction

  function automatic int order_pos(input int k);
    return s_lsb ? k : (s_n - 1 - k);
  endfunction

  initial begin
    forever begin
      @(sck);
      if (s_on && ((sck != s_cpol) ^ s_cpha)) begin
        if (s_k < s_n) s_cap = s_cap | (16'(mosi) << order_pos(s_k));
        s_k++;
        miso = (s_k < s_n) ? bit_at(s_word, order_pos(s_k)) : 1'b0;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // each access occupies one cycle, starting and ending at a falling edge
  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic poll(input logic [4:0] a, input int b, output int cyc);
    logic [15:0] v;
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(a, v);
      if (bit_at(v, b)) break;
      cyc++;
    end
  endtask

  task automatic arm(input logic [15:0] ctrl, input logic [15:0] word, input int n);
    s_cpol = ctrl[4]; s_cpha = ctrl[3]; s_lsb = ctrl[6]; s_n = n;
    s_word = word; s_cap = '0; s_k = 0;
    miso = bit_at(word, order_pos(0));
    s_on = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] m;
    int cyc;
    int toggles;
    logic sck0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1", "ctrl", v, 16'h0);
    rd(A_STAT, v); chk("R1", "status", v, 16'h0);
    rd(A_DIV, v);  chk("R1", "divisor", v, 16'h0);
    rd(A_DATA, v); chk("R1", "data", v, 16'h0);
    rd(A_INT, v);  chk("R1", "intflag", v, 16'h0);
    chk("R1", "irq", irq, 1'b0);
    chk("R1", "sck", sck, 1'b0);

    // table walk: R2 length, R3 duration, R4 mode, R5 order, R6 data, R7 flag
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, V_CTRL[i]);
      wr(A_DIV, V_DIV[i]);
      chk("R4", $sformatf("idle sck v%0d", i), sck, V_CTRL[i][4]);
      m = 16'((32'h1 << V_N[i]) - 1);
      arm(V_CTRL[i], V_SL[i], V_N[i]);
      wr(A_DATA, V_TX[i]);
      poll(A_STAT, 7, cyc);
      s_on = 1'b0;
      chk("R3", $sformatf("cycles v%0d", i), cyc, V_CYC[i]);
      chk("R2/R4/R5", $sformatf("mosi word v%0d", i), s_cap, V_TX[i] & m);
      rd(A_DATA, v);
      chk("R6/R4/R5", $sformatf("rx word v%0d", i), v, V_SL[i] & m);
      rd(A_STAT, v);
      chk("R7", $sformatf("flag cleared v%0d", i), v, 16'h0);
      wr(A_INT, 16'h1);
    end

    // R8 write collision
    wr(A_CTRL, 16'h0020);
    wr(A_DIV, 16'h08);
    arm(16'h0020, 16'h0096, 8);
    wr(A_DATA, 16'h003C);
    wr(A_DATA, 16'h00FF);
    rd(A_STAT, v); chk("R8", "collision set", v, 16'h0040);
    rd(A_STAT, v); chk("R8", "collision cleared", v, 16'h0000);
    poll(A_STAT, 7, cyc);
    s_on = 1'b0;
    chk("R8", "ignored word not sent", s_cap, 16'h003C);
    rd(A_DATA, v); chk("R8", "rx after collision", v, 16'h0096);
    wr(A_INT, 16'h1);

    // R9 overrun, R7 data access without status read keeps flag
    arm(16'h0020, 16'h0011, 8);
    wr(A_DATA, 16'h0022);
    poll(A_INT, 0, cyc);
    s_on = 1'b0;
    wr(A_INT, 16'h1);
    arm(16'h0020, 16'h0044, 8);
    wr(A_DATA, 16'h0055);
    poll(A_INT, 0, cyc);
    s_on = 1'b0;
    rd(A_DATA, v); chk("R9", "newest word kept", v, 16'h0044);
    rd(A_STAT, v); chk("R9", "overrun and flag", v, 16'h00A0);
    rd(A_STAT, v); chk("R9", "overrun cleared", v, 16'h0080);
    rd(A_DATA, v);
    rd(A_STAT, v); chk("R7", "flag cleared after sequence", v, 16'h0000);
    wr(A_INT, 16'h1);
    rd(A_INT, v);  chk("R10", "intflag cleared", v, 16'h0);

    // R10 interrupt
    wr(A_CTRL, 16'h00A0);
    arm(16'h00A0, 16'h0077, 8);
    wr(A_DATA, 16'h0088);
    poll(A_INT, 0, cyc);
    s_on = 1'b0;
    chk("R10", "irq raised", irq, 1'b1);
    wr(A_INT, 16'h0);
    chk("R10", "write 0 no effect", irq, 1'b1);
    wr(A_CTRL, 16'h0020);
    chk("R10", "irq masked", irq, 1'b0);
    wr(A_CTRL, 16'h00A0);
    chk("R10", "irq unmasked", irq, 1'b1);
    wr(A_INT, 16'h1);
    chk("R10", "irq cleared", irq, 1'b0);
    rd(A_STAT, v);
    rd(A_DATA, v);

    // R11 no transfer without master select
    wr(A_CTRL, 16'h0000);
    @(negedge clk);
    sck0 = sck;
    wr(A_DATA, 16'h00AA);
    toggles = 0;
    for (int i = 0; i < 100; i++) begin
      rd(A_STAT, v);
      if (sck != sck0) toggles++;
    end
    chk("R11", "sck toggles", toggles, 0);
    chk("R11", "status", v, 16'h0);
    rd(A_INT, v); chk("R11", "intflag", v, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule